// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address used inside a synchronous memory during a four-beat burst. Two start strobes can begin a burst. One comes from a processor and one from a cache controller. Either strobe captures the external address into an internal register. From then on, an advance input steps a 2-bit beat counter, and the counter rewrites only the two lowest address bits. The upper bits pass straight from the register to the output.

A static mode pin picks the beat order. In linear order the low bits count upward modulo four from the captured value. In interleaved order they are the captured value XOR the beat count. A chip-enable input, when high, masks the processor strobe so that another device on the same bus can own the cycle. The controller strobe is never masked.

The output is combinational from the registers. A load or a step that is taken at a clock edge therefore shows on the output right after that edge.

Top module: `burstAddrSeq`

## Requirements
- R1: A high `ctrlStrobe` at a clock edge loads `addrIn`, so `addrOut` equals that `addrIn` after the edge, whatever `chipEn1` is.
- R2: A high `procStrobe` with `chipEn1` low at a clock edge loads `addrIn` in the same way.
- R3: While `chipEn1` is high, `procStrobe` has no effect. The register keeps its address and the counter keeps its value unless `advance` or `ctrlStrobe` acts.
- R4: With `interleaveMode` = 0 (linear), the low two bits after k advances equal (start + k) mod 4.
- R5: With `interleaveMode` = 1 (interleaved), the low two bits after k advances equal start XOR (k mod 4).
- R6: Between loads, `addrOut[ADDR_W-1:2]` stays equal to the captured upper bits.
- R7: An edge with `advance` low and no load leaves `addrOut` unchanged.
- R8: The fourth advance after a load brings the low bits back to the start value.
- R9: A load in the middle of a burst takes effect at once and restarts the counter. A load wins over an `advance` at the same edge.
- R10: An asynchronous low `rstN` clears the register and the counter, so `addrOut` reads 0.
- R11: When both strobes are high and `chipEn1` is low, the address is loaded once and the counter restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| procStrobe | input | 1 | Processor burst start, masked by chipEn1 |
| ctrlStrobe | input | 1 | Cache controller burst start |
| chipEn1 | input | 1 | High masks procStrobe |
| advance | input | 1 | Step to the next beat |
| interleaveMode | input | 1 | Static: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | External address |
| addrOut | output | ADDR_W | Burst word address |

## Verification
A wrong beat counter shows in `addrOut[1:0]` on the first edge after the fault, because the output has no register after the counter. A wrong address register shows on the upper bits at the same point. A strobe that is wrongly accepted or dropped also appears one edge later, as a changed or stale address. Hold, wrap and masking errors therefore surface within the single cycle that follows the stimulus, and the stimulus table compares the output after every edge.

// File: rtl/burstSeqPkg.sv
package burstSeqPkg;

  // Command strobes sent from the control half to the datapath half
  typedef struct packed {
    logic load;   // capture a new start address, restart the count
    logic step;   // move to the next beat
  } seqCmd_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } beatOrder_e;

  localparam int BEAT_BITS = 2;

endpackage

// File: rtl/burstSeqCtl.sv
module burstSeqCtl
  import burstSeqPkg::*;
(
  input  logic    procStrobe,
  input  logic    ctrlStrobe,
  input  logic    chipEn1,
  input  logic    advance,
  output seqCmd_t cmd
);

  logic procTaken;

  // The processor strobe counts only while chipEn1 is low. It has first
  // claim on the load, and the controller strobe covers the other cases.
  always_comb begin
    procTaken = procStrobe & ~chipEn1;
    cmd.load  = 1'b0;
    cmd.step  = 1'b0;
    if (procTaken) begin
      cmd.load = 1'b1;
    end else if (ctrlStrobe) begin
      cmd.load = 1'b1;
    end else if (advance) begin
      cmd.step = 1'b1;
    end
  end

endmodule

// File: rtl/burstOrderMap.sv
module burstOrderMap
  import burstSeqPkg::*;
#(
  parameter int CW = BEAT_BITS
) (
  input  logic          interleaveMode,
  input  logic [CW-1:0] startLow,
  input  logic [CW-1:0] beatCnt,
  output logic [CW-1:0] lowOut
);

  logic [CW-1:0] linLow;
  logic [CW-1:0] xorLow;

  assign linLow = startLow + beatCnt;

  genvar b;
  generate
    for (b = 0; b < CW; b++) begin : g_xorBit
      assign xorLow[b] = startLow[b] ^ beatCnt[b];
    end
  endgenerate

  always_comb begin
    unique case (beatOrder_e'(interleaveMode))
      ORDER_INTERLEAVE: lowOut = xorLow;
      default:          lowOut = linLow;
    endcase
  end

endmodule

// File: rtl/burstSeqDatapath.sv
module burstSeqDatapath
  import burstSeqPkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int CW = BEAT_BITS;
  localparam int UW = ADDR_W - CW;

  logic [UW-1:0] upperReg;
  logic [CW-1:0] startReg;
  logic [CW-1:0] beatCnt;
  logic [CW-1:0] lowOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperReg <= '0;
      startReg <= '0;
    end else if (cmd.load) begin
      upperReg <= addrIn[ADDR_W-1:CW];
      startReg <= addrIn[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
    end else if (cmd.load) begin
      beatCnt <= '0;
    end else if (cmd.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  burstOrderMap #(.CW(CW)) u_map (
    .interleaveMode(interleaveMode),
    .startLow      (startReg),
    .beatCnt       (beatCnt),
    .lowOut        (lowOut)
  );

  assign addrOut = {upperReg, lowOut};

endmodule

// File: rtl/burstAddrSeq.sv
module burstAddrSeq
  import burstSeqPkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              chipEn1,
  input  logic              advance,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  seqCmd_t cmd;

  burstSeqCtl u_ctl (
    .procStrobe(procStrobe),
    .ctrlStrobe(ctrlStrobe),
    .chipEn1   (chipEn1),
    .advance   (advance),
    .cmd       (cmd)
  );

  burstSeqDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .interleaveMode(interleaveMode),
    .addrIn        (addrIn),
    .addrOut       (addrOut)
  );

endmodule

// File: rtl/burstSeqChk.sv
module burstSeqChk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobe,
  input logic              ctrlStrobe,
  input logic              chipEn1,
  input logic              advance,
  input logic              interleaveMode,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut
);

  // R1
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStrobe |=> addrOut == $past(addrIn));

  // R2
  proc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && !chipEn1) |=> addrOut == $past(addrIn));

  // R3
  proc_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn1 && !ctrlStrobe && !advance) |=>
      ($stable(addrOut) || !$stable(interleaveMode)));

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobe && !(procStrobe && !chipEn1)) |=>
      $stable(addrOut[ADDR_W-1:2]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !ctrlStrobe && !(procStrobe && !chipEn1)) |=>
      ((addrOut[1:0] == $past(addrOut[1:0]) + 2'd1) ||
       interleaveMode || $past(interleaveMode)));

endmodule

bind burstAddrSeq burstSeqChk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_burstAddrSeq.sv
module tb_burstAddrSeq;

  localparam int AW = 19;
  localparam int VW = 5 + 2 * AW;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procStrobe = 1'b0;
  logic          ctrlStrobe = 1'b0;
  logic          chipEn1 = 1'b0;
  logic          advance = 1'b0;
  logic          interleaveMode = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  burstAddrSeq #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .chipEn1(chipEn1), .advance(advance), .interleaveMode(interleaveMode),
    .addrIn(addrIn), .addrOut(addrOut)
  );

  // {proc, ctrl, chipEn1, advance, mode, addrIn, expected addrOut}
  localparam logic [VW-1:0] VEC [NV] = '{
    {5'b01000, 19'h12345, 19'h12345},  // R1 controller load, start 01
    {5'b00010, 19'h00000, 19'h12346},  // R4 linear beat 2
    {5'b00010, 19'h00000, 19'h12347},  // R4 linear beat 3
    {5'b00010, 19'h00000, 19'h12344},  // R4 R6 linear beat 4, upper kept
    {5'b00010, 19'h00000, 19'h12345},  // R8 wrap to start
    {5'b00000, 19'h7FFFF, 19'h12345},  // R7 hold without advance
    {5'b10100, 19'h7FFFF, 19'h12345},  // R3 proc masked by chipEn1
    {5'b10000, 19'h00AB2, 19'h00AB2},  // R2 proc load
    {5'b00010, 19'h00000, 19'h00AB3},  // R4 linear step
    {5'b01010, 19'h40003, 19'h40003},  // R9 mid-burst reload beats advance
    {5'b00010, 19'h00000, 19'h40000},  // R9 count restarted
    {5'b01001, 19'h55556, 19'h55556},  // R1 interleaved load, start 10
    {5'b00011, 19'h00000, 19'h55557},  // R5 10^01
    {5'b00011, 19'h00000, 19'h55554},  // R5 10^10
    {5'b00011, 19'h00000, 19'h55555},  // R5 R6 10^11
    {5'b00011, 19'h00000, 19'h55556},  // R8 interleaved wrap
    {5'b11001, 19'h00003, 19'h00003},  // R11 both strobes
    {5'b10111, 19'h7FFFF, 19'h00002}   // R3 masked proc, advance acts: 11^01
  };

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addrOut !== exp) begin
      fails++;
      $display("FAIL %s: addrOut=%h expected=%h", req, addrOut, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    @(negedge clk);
    {procStrobe, ctrlStrobe, chipEn1, advance, interleaveMode} = v[VW-1 -: 5];
    addrIn = v[2*AW-1 -: AW];
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    #5;
    check("R10", '0);  // still in reset
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R10", '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("vec%0d", i), VEC[i][AW-1:0]);
    end

    // R9 reload while a burst is in progress, in linear order
    drive({5'b01000, 19'h2AAA9, 19'h0});
    drive({5'b00010, 19'h0, 19'h0});
    drive({5'b00010, 19'h0, 19'h0});
    check("R9 pre", 19'h2AAAB);
    drive({5'b10010, 19'h11110, 19'h0});
    check("R9 reload", 19'h11110);

    // R10 asynchronous reset in mid-burst
    drive({5'b00010, 19'h0, 19'h0});
    @(negedge clk);
    {procStrobe, ctrlStrobe, chipEn1, advance} = 4'b0000;
    rstN = 1'b0;
    #1;
    check("R10 async", '0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R10 held", '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule